// File: doc/BRIEF.md
# Signed Two's Complement Array Multiplier

This block multiplies two signed N-bit operands and returns their exact 2N-bit two's complement product. It never sign-extends a partial product. Instead, each product bit that pairs one operand's sign bit with a non-sign bit of the other operand is inverted. The sign-times-sign bit stays as it is. Two constant ones are placed in fixed columns. With these changes every bit in the matrix has positive weight, and no column grows taller than it would in an unsigned multiply of the same size.

The matrix is reduced row by row with carry-save full adders into one sum vector and one carry vector. A ripple adder then combines the two into the product. The block is meant for small operands such as filter coefficients and samples, from about 6 to 16 bits. One register stage sits at the output: a strobe on the input side produces a registered product and a valid flag one clock later.

Top module: `sgn_array_mul`

## Requirements
- R1: While the synchronous active-low reset is asserted at a clock edge, the output valid flag and the product register are cleared to zero, whatever the operand and strobe inputs are.
- R2: When the input strobe is high at a clock edge, the output valid flag is high after that edge.
- R3: When the input strobe is low at a clock edge, the output valid flag is low after that edge and the product output keeps its previous value.
- R4: For every pair of N-bit operands, the product taken with the strobe equals the signed product of the operands, read as a 2N-bit two's complement value. The operand MSB weighs -2^(N-1), and any carry out of column 2N-1 is dropped.
- R5: When both operands are the most negative value (only the MSB set), the product is +2^(2N-2). This is 256 at N=5.
- R6: An all-ones operand means -1. So (-1)*(-1) gives 1, and (-1) times the most negative value gives +2^(N-1).
- R7: At N=16 the product matches the signed reference for arbitrary operand pairs, both signs included.
- R8: A zero operand gives a zero product, whatever the value of the other operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Operand strobe |
| a_in | input | N | Multiplicand, two's complement |
| x_in | input | N | Multiplier, two's complement |
| out_vld | output | 1 | Product valid, one cycle after the strobe |
| prod_out | output | 2N | Signed product |

## Verification
The bench builds two copies of the block, one at N=5 and one at N=16. At N=5 the operand space is small enough to try all 1024 pairs, so every corner of the complemented matrix is reached. This includes both sign bits set together and the dropped carry out of the top column. The N=16 copy takes seeded random pairs plus directed extremes. This shows that the placement of the constant ones and the row-by-row carry-save chain scale correctly with the parameter.

// File: rtl/smul_pkg.sv
// Package for the signed array multiplier.
// Holds the width rules that all submodules share.
package smul_pkg;

    // Product width for an n-bit by n-bit signed multiply.
    function automatic int prod_width(input int n);
        return 2 * n;
    endfunction

    // Number of matrix rows: one per multiplier bit, plus one row of constants.
    function automatic int row_count(input int n);
        return n + 1;
    endfunction

endpackage

// File: rtl/smul_ppgen.sv
// Partial-product generator.
// Builds the positive-weight bit matrix, one row per bit of x_i,
// plus one row that holds the constant ones.
// A bit pairing exactly one sign bit with a non-sign bit is inverted.
// The sign-times-sign bit is left as it is.
// The constant row carries a one in column N and a one in column 2N-1.
// Assumes N >= 2.
module smul_ppgen #(
    parameter int N = 5
) (
    input  logic [N-1:0]                                          a_i,
    input  logic [N-1:0]                                          x_i,
    output logic [smul_pkg::row_count(N)-1:0][smul_pkg::prod_width(N)-1:0] rows_o
);
    localparam int W = smul_pkg::prod_width(N);

    // Place each AND term at column i+j, inverting the mixed-sign terms.
    always_comb begin
        rows_o = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                rows_o[j][i+j] = (a_i[i] & x_i[j]) ^ ((i == N-1) != (j == N-1));
            end
        end
        rows_o[N][N]   = 1'b1;
        rows_o[N][W-1] = 1'b1;
    end

endmodule

// File: rtl/smul_csa_array.sv
// Carry-save reduction array.
// Folds the matrix rows into one sum vector and one carry vector,
// one full-adder row per extra matrix row.
// Where an input column is zero, the full adder acts as a half adder.
// A carry leaving column 2N-1 is dropped.
module smul_csa_array #(
    parameter int N = 5
) (
    input  logic [smul_pkg::row_count(N)-1:0][smul_pkg::prod_width(N)-1:0] rows_i,
    output logic [smul_pkg::prod_width(N)-1:0]                             sum_o,
    output logic [smul_pkg::prod_width(N)-1:0]                             carry_o
);
    localparam int W = smul_pkg::prod_width(N);
    localparam int R = smul_pkg::row_count(N);

    logic [W-1:0] s_st [R-1];
    logic [W-1:0] c_st [R-1];

    // The first two rows seed the redundant pair.
    assign s_st[0] = rows_i[0];
    assign c_st[0] = rows_i[1];

    for (genvar k = 1; k < R - 1; k++) begin : g_lvl
        logic [W-2:0] maj;
        // Full-adder sum per column.
        assign s_st[k] = s_st[k-1] ^ c_st[k-1] ^ rows_i[k+1];
        // Full-adder carry per column, moved one column up.
        assign maj = (s_st[k-1][W-2:0] & c_st[k-1][W-2:0])
                   | (s_st[k-1][W-2:0] & rows_i[k+1][W-2:0])
                   | (c_st[k-1][W-2:0] & rows_i[k+1][W-2:0]);
        assign c_st[k] = {maj, 1'b0};
    end

    assign sum_o   = s_st[R-2];
    assign carry_o = c_st[R-2];

endmodule

// File: rtl/smul_cpa.sv
// Final carry-propagate adder: a ripple chain 2N bits wide.
// The carry out of the top bit is dropped.
module smul_cpa #(
    parameter int W = 10
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] cy;

    assign cy[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Sum bit of column i.
        assign sum_o[i] = op_a[i] ^ op_b[i] ^ cy[i];
        if (i < W - 1) begin : g_cy
            // Carry into column i+1.
            assign cy[i+1] = (op_a[i] & op_b[i]) | (op_a[i] & cy[i]) | (op_b[i] & cy[i]);
        end
    end

endmodule

// File: rtl/sgn_array_mul.sv
// Top level of the signed two's complement array multiplier.
// Combinational path: matrix generation, carry-save array, ripple adder.
// The result is registered together with a valid flag.
// Assumes N >= 2 and a synchronous active-low reset.
module sgn_array_mul #(
    parameter int N = 5
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_vld,
    input  logic [N-1:0]                       a_in,
    input  logic [N-1:0]                       x_in,
    output logic                               out_vld,
    output logic [smul_pkg::prod_width(N)-1:0] prod_out
);
    localparam int W = smul_pkg::prod_width(N);
    localparam int R = smul_pkg::row_count(N);

    logic [R-1:0][W-1:0] rows;
    logic [W-1:0]        red_sum;
    logic [W-1:0]        red_cry;
    logic [W-1:0]        prod_nxt;

    smul_ppgen #(.N(N)) u_ppgen (
        .a_i    (a_in),
        .x_i    (x_in),
        .rows_o (rows)
    );

    smul_csa_array #(.N(N)) u_csa (
        .rows_i  (rows),
        .sum_o   (red_sum),
        .carry_o (red_cry)
    );

    smul_cpa #(.W(W)) u_cpa (
        .op_a  (red_sum),
        .op_b  (red_cry),
        .sum_o (prod_nxt)
    );

    // Capture the product on a strobe; the valid flag follows the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            prod_out <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                prod_out <= prod_nxt;
            end
        end
    end

endmodule

// File: rtl/smul_chk.sv
// Checker for sgn_array_mul, attached to it by a bind.
// It compares the registered product with a reference model of the
// signed product, and checks the timing of the valid flag.
module smul_chk #(
    parameter int N = 5
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               in_vld,
    input logic [N-1:0]                       a_in,
    input logic [N-1:0]                       x_in,
    input logic                               out_vld,
    input logic [smul_pkg::prod_width(N)-1:0] prod_out
);
    localparam int W = smul_pkg::prod_width(N);

    logic signed [W-1:0] a_ext;
    logic signed [W-1:0] x_ext;
    logic signed [W-1:0] ref_p;
    logic                both_min;

    assign a_ext    = $signed({{N{a_in[N-1]}}, a_in});
    assign x_ext    = $signed({{N{x_in[N-1]}}, x_in});
    assign ref_p    = a_ext * x_ext;
    assign both_min = (a_in == {1'b1, {(N-1){1'b0}}}) && (x_in == {1'b1, {(N-1){1'b0}}});

    // R1
    rst_clr_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_vld && prod_out == '0));

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(prod_out)));

    // R4
    prod_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> prod_out == $past(ref_p));

    // R5
    min_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && both_min) |=> prod_out == ({{(W-1){1'b0}}, 1'b1} << (W-2)));

endmodule

bind sgn_array_mul smul_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .a_in     (a_in),
    .x_in     (x_in),
    .out_vld  (out_vld),
    .prod_out (prod_out)
);

// File: tb/tb_sgn_array_mul.sv
// Bench for sgn_array_mul with two copies of the block.
// The N=5 copy gets every operand pair; the N=16 copy gets seeded random
// pairs. Both get directed corner cases.
module tb_sgn_array_mul;
    localparam int NS = 5;
    localparam int NW = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic vld;
    logic [NS-1:0]   a5, x5;
    logic [NW-1:0]   a16, x16;
    logic            ov5, ov16;
    logic [2*NS-1:0] p5;
    logic [2*NW-1:0] p16;

    int checks = 0;
    int errors = 0;
    logic [2*NS-1:0] last5;
    logic [2*NW-1:0] last16;

    always #10 clk = ~clk;

    sgn_array_mul #(.N(NS)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(vld), .a_in(a5), .x_in(x5),
        .out_vld(ov5), .prod_out(p5));

    sgn_array_mul #(.N(NW)) dut16 (
        .clk(clk), .rst_n(rst_n), .in_vld(vld), .a_in(a16), .x_in(x16),
        .out_vld(ov16), .prod_out(p16));

    function automatic logic [2*NS-1:0] ref5(input logic [NS-1:0] a, input logic [NS-1:0] x);
        int p;
        p = int'($signed(a)) * int'($signed(x));
        return p[2*NS-1:0];
    endfunction

    function automatic logic [2*NW-1:0] ref16(input logic [NW-1:0] a, input logic [NW-1:0] x);
        int p;
        p = int'($signed(a)) * int'($signed(x));
        return p[2*NW-1:0];
    endfunction

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one operand set, then check both copies one cycle later.
    task automatic apply(input logic v, input logic [NS-1:0] ia5, input logic [NS-1:0] ix5,
                         input logic [NW-1:0] ia16, input logic [NW-1:0] ix16,
                         input string tag5, input string tag16);
        logic [2*NS-1:0] e5;
        logic [2*NW-1:0] e16;
        @(negedge clk);
        vld = v; a5 = ia5; x5 = ix5; a16 = ia16; x16 = ix16;
        e5  = v ? ref5(ia5, ix5) : last5;
        e16 = v ? ref16(ia16, ix16) : last16;
        @(negedge clk);
        if (v) begin
            chk(ov5 == 1'b1,  "R2 valid n5",  longint'(ov5),  1);
            chk(ov16 == 1'b1, "R2 valid n16", longint'(ov16), 1);
        end else begin
            chk(ov5 == 1'b0,  "R3 valid low n5",  longint'(ov5),  0);
            chk(ov16 == 1'b0, "R3 valid low n16", longint'(ov16), 0);
        end
        chk(p5 == e5,   tag5,  longint'(p5),  longint'(e5));
        chk(p16 == e16, tag16, longint'(p16), longint'(e16));
        last5 = p5; last16 = p16;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: the strobe and operands are active during reset and must have no effect.
        rst_n = 1'b0; vld = 1'b1; a5 = 5'd3; x5 = 5'd3; a16 = 16'd7; x16 = 16'd9;
        repeat (3) @(negedge clk);
        chk(ov5 == 1'b0 && ov16 == 1'b0, "R1 valid cleared", longint'({ov5, ov16}), 0);
        chk(p5 == '0 && p16 == '0, "R1 product cleared", longint'(p5), 0);
        rst_n = 1'b1; vld = 1'b0;
        last5 = '0; last16 = '0;

        // R4 exhaustive at N=5, R7 random at N=16
        for (int ia = 0; ia < 32; ia++) begin
            for (int ix = 0; ix < 32; ix++) begin
                apply(1'b1, ia[NS-1:0], ix[NS-1:0], 16'($urandom), 16'($urandom),
                      "R4 exhaustive n5", "R7 random n16");
            end
        end

        // R5 both operands most negative
        apply(1'b1, 5'h10, 5'h10, 16'h8000, 16'h8000, "R5 min*min n5", "R5 min*min n16");
        chk(p5 == 10'd256, "R5 value n5", longint'(p5), 256);
        chk(p16 == 32'h4000_0000, "R5 value n16", longint'(p16), 64'h4000_0000);
        // R6 all-ones operands
        apply(1'b1, 5'h1f, 5'h1f, 16'hffff, 16'hffff, "R6 -1*-1 n5", "R6 -1*-1 n16");
        chk(p5 == 10'd1 && p16 == 32'd1, "R6 value -1*-1", longint'(p5), 1);
        apply(1'b1, 5'h1f, 5'h10, 16'h8000, 16'hffff, "R6 -1*min n5", "R6 min*-1 n16");
        chk(p5 == 10'd16 && p16 == 32'h8000, "R6 value -1*min", longint'(p16), 64'h8000);
        // R8 zero operand
        apply(1'b1, 5'h00, 5'h15, 16'h9abc, 16'h0000, "R8 zero n5", "R8 zero n16");
        chk(p5 == '0 && p16 == '0, "R8 value zero", longint'(p5), 0);

        // R3 hold: load a known product, then drive other operands without the strobe
        apply(1'b1, 5'h0b, 5'h1a, 16'h7fff, 16'h8001, "R4 load n5", "R7 load n16");
        apply(1'b0, 5'h0f, 5'h0f, 16'h1234, 16'h4321, "R3 hold n5", "R3 hold n16");
        apply(1'b0, 5'h10, 5'h01, 16'h0001, 16'h0001, "R3 hold2 n5", "R3 hold2 n16");

        // R7 more random after idle
        for (int k = 0; k < 200; k++) begin
            apply(1'b1, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                  "R4 random n5", "R7 random n16");
        end

        // R1 reset in mid-run clears the outputs again
        @(negedge clk);
        rst_n = 1'b0; vld = 1'b1;
        @(negedge clk);
        chk(ov5 == 1'b0 && p5 == '0 && ov16 == 1'b0 && p16 == '0,
            "R1 mid-run reset", longint'(p5), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule